// File: doc/BRIEF.md
# Strobed Parallel Port Latch

This block drives and samples a byte-wide bidirectional pin group. Each pin has its own direction bit. An output pin drives the value held in a port output register. An input pin is sampled through a two-flop synchroniser. A separate strobe input marks the moment an external source has valid data on the pins. When the chosen edge of that strobe arrives, the block copies the synchronised pin values into a capture latch and raises a strobe-seen flag.

Software reaches four registers over a simple synchronous bus. The bus has an address, separate read and write enables, and write and read data. Read data follows the address combinationally. Side effects of a read take place at the clock edge during which the read enable is high.

The flag clears only through a two-step handshake. First a status read must see the flag set. A later read of the capture latch then clears it. A fresh strobe edge always takes priority over the clearing read.

Top module: `strobe_port_latch`

## Requirements
- R1: After reset the direction register, the port output register, the capture latch and the status register are all 0. As a result pinOe is 0 and pinOut is 0.
- R2: A write to offset 0x7 loads the direction register, and pinOe follows it from the next cycle (1 = output, 0 = input). A write to offset 0x3 loads the port output register, and pinOut follows it from the next cycle.
- R3: A read of offset 0x3 returns, bit by bit, the port output register where the direction bit is 1 and the synchronised pin value where it is 0. A pin change shows up in this value two clock edges after it occurs.
- R4: Status register bit 1 selects the active strobe edge (0 = falling, 1 = rising). On an active edge, the latch at offset 0x5 captures the synchronised pins and status bit 7 (the flag) is set. Both are visible after the third clock edge following the strobe change.
- R5: The latch keeps its value when the pins change later. A strobe edge of the non-selected polarity neither captures nor sets the flag.
- R6: A status read (offset 0x2) that returns the flag set, followed by a read of the latch, clears the flag.
- R7: A latch read that was not preceded by a status read returning the flag set leaves the flag set.
- R8: Any write to the status register cancels a pending clear, so a following latch read leaves the flag set.
- R9: If an active edge is detected in the same cycle as the clearing latch read, the flag stays set and the latch takes the new pin values.
- R10: A status read that returns the flag clear does not prepare a clear. If a strobe then sets the flag, a latch read leaves it set.
- R11: Status bits other than 7 and 1 read 0, and bit 7 cannot be written. Offsets other than 0x2, 0x3, 0x5 and 0x7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset |
| busWr | input | 1 | Write enable |
| busRd | input | 1 | Read enable (qualifies read side effects) |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data for the current address |
| strobeIn | input | 1 | Asynchronous strobe input |
| pinIn | input | 8 | Sampled pin levels |
| pinOut | output | 8 | Pin drive values |
| pinOe | output | 8 | Pin output enables |

## Verification
On every cycle, the assertions check several properties. pinOe and pinOut must follow register writes. Every capture must be followed by a set flag. The flag may only fall after a latch read. The latch may only change on a capture. Reserved status bits and unmapped offsets must read 0.

Other behaviours can only be shown by the bench's ordered scenarios. These are the two-step clear and the cases that break it: a latch read with no status read first, a status write in between, and a status read that saw a clear flag. They also include the strobe-versus-clear collision and rejection of the non-selected edge.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 3'h2;
  localparam logic [ADDR_W-1:0] OFS_PORT  = 3'h3;
  localparam logic [ADDR_W-1:0] OFS_LATCH = 3'h5;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 3'h7;

  localparam int FLAG_BIT = 7;
  localparam int EDGE_BIT = 1;

  typedef struct packed {
    logic wrPort;
    logic wrDir;
    logic wrStat;
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/spl_sync.sv
module spl_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/spl_ctrl.sv
module spl_ctrl
  import spl_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWr,
  input  logic          busRd,
  input  logic          strobeSync,
  input  logic          edgeRise,
  output ctrlStrobes_t  strb,
  output logic          flagQ
);
  logic strobePrev;
  logic edgeDet;
  logic armedQ;
  logic rdStat;
  logic rdLatch;

  always_ff @(posedge clk) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= strobeSync;
  end

  always_comb begin
    if (edgeRise) edgeDet = strobeSync & ~strobePrev;
    else          edgeDet = ~strobeSync & strobePrev;
  end

  assign rdStat  = busRd && (busAddr == OFS_STAT);
  assign rdLatch = busRd && (busAddr == OFS_LATCH);

  always_comb begin
    strb.wrPort  = busWr && (busAddr == OFS_PORT);
    strb.wrDir   = busWr && (busAddr == OFS_DIR);
    strb.wrStat  = busWr && (busAddr == OFS_STAT);
    strb.capture = edgeDet;
  end

  // a new capture outranks the clearing read
  always_ff @(posedge clk) begin
    if (!rstN)                  flagQ <= 1'b0;
    else if (edgeDet)           flagQ <= 1'b1;
    else if (rdLatch && armedQ) flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  armedQ <= 1'b0;
    else if (strb.wrStat)       armedQ <= 1'b0;
    else if (rdStat)            armedQ <= flagQ;
    else if (rdLatch && armedQ) armedQ <= 1'b0;
  end
endmodule

// File: rtl/spl_datapath.sv
module spl_datapath
  import spl_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [AW-1:0]    busAddr,
  input  logic [WIDTH-1:0] busWData,
  input  logic [WIDTH-1:0] pinSync,
  input  logic             flagQ,
  output logic [WIDTH-1:0] busRData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic             edgeRise,
  output logic [WIDTH-1:0] latchQ
);
  logic [WIDTH-1:0] outRegQ;
  logic [WIDTH-1:0] dirRegQ;
  logic             edgeSelQ;
  logic [WIDTH-1:0] portView;
  logic [WIDTH-1:0] statView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outRegQ  <= '0;
      dirRegQ  <= '0;
      edgeSelQ <= 1'b0;
      latchQ   <= '0;
    end else begin
      if (strb.wrPort)  outRegQ  <= busWData;
      if (strb.wrDir)   dirRegQ  <= busWData;
      if (strb.wrStat)  edgeSelQ <= busWData[EDGE_BIT];
      if (strb.capture) latchQ   <= pinSync;
    end
  end

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_view
      assign portView[b] = dirRegQ[b] ? outRegQ[b] : pinSync[b];
    end
  endgenerate

  always_comb begin
    statView           = '0;
    statView[FLAG_BIT] = flagQ;
    statView[EDGE_BIT] = edgeSelQ;
  end

  always_comb begin
    case (busAddr)
      OFS_STAT:  busRData = statView;
      OFS_PORT:  busRData = portView;
      OFS_LATCH: busRData = latchQ;
      OFS_DIR:   busRData = dirRegQ;
      default:   busRData = '0;
    endcase
  end

  assign pinOut   = outRegQ;
  assign pinOe    = dirRegQ;
  assign edgeRise = edgeSelQ;
endmodule

// File: rtl/strobe_port_latch.sv
module strobe_port_latch
  import spl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  input  logic              strobeIn,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe
);
  ctrlStrobes_t      strb;
  logic              flagQ;
  logic              edgeRise;
  logic              strobeSync;
  logic [DATA_W-1:0] pinSync;
  logic [DATA_W-1:0] latchQ;

  spl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uStrobeSync (
    .clk(clk), .rstN(rstN), .asyncIn(strobeIn), .syncOut(strobeSync)
  );

  spl_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) uPinSync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(pinSync)
  );

  spl_ctrl #(.AW(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .strobeSync(strobeSync), .edgeRise(edgeRise), .strb(strb), .flagQ(flagQ)
  );

  spl_datapath #(.WIDTH(DATA_W), .AW(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWData(busWData),
    .pinSync(pinSync), .flagQ(flagQ), .busRData(busRData), .pinOut(pinOut),
    .pinOe(pinOe), .edgeRise(edgeRise), .latchQ(latchQ)
  );
endmodule

// File: rtl/spl_checker.sv
module spl_checker
  import spl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busWData,
  input logic [DATA_W-1:0] busRData,
  input logic [DATA_W-1:0] pinOut,
  input logic [DATA_W-1:0] pinOe,
  input logic              capture,
  input logic              flagQ,
  input logic [DATA_W-1:0] latchQ
);
  localparam logic [DATA_W-1:0] STAT_RSVD =
    ~((DATA_W'(1) << FLAG_BIT) | (DATA_W'(1) << EDGE_BIT));

  logic mapped;
  assign mapped = (busAddr == OFS_STAT) || (busAddr == OFS_PORT) ||
                  (busAddr == OFS_LATCH) || (busAddr == OFS_DIR);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_DIR) |=> pinOe == $past(busWData));

  // R2
  out_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_PORT) |=> pinOut == $past(busWData));

  // R4
  capture_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> flagQ);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(busRd && busAddr == OFS_LATCH));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> $stable(latchQ));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRData == '0);

  // R11
  stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFS_STAT) |-> (busRData & STAT_RSVD) == '0);
endmodule

bind strobe_port_latch spl_checker uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWData(busWData), .busRData(busRData), .pinOut(pinOut), .pinOe(pinOe),
  .capture(strb.capture), .flagQ(flagQ), .latchQ(latchQ)
);

// File: tb/strobe_port_latch_test.sv
module strobe_port_latch_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       isWr;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] expv;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t [0:NVEC-1] VECS = '{
    '{1'b1, 3'h7, 8'hF0, 8'h00, 4'd2},  // R2 upper nibble outputs
    '{1'b1, 3'h3, 8'hA5, 8'h00, 4'd2},  // R2 output register
    '{1'b0, 3'h7, 8'h00, 8'hF0, 4'd2},  // R2 direction readback
    '{1'b0, 3'h3, 8'h00, 8'hAC, 4'd3},  // R3 mix: A0 out | 0C from pins 3C
    '{1'b0, 3'h2, 8'h00, 8'h00, 4'd11}, // R11 status idle
    '{1'b1, 3'h2, 8'hFF, 8'h00, 4'd11}, // R11 write all ones
    '{1'b0, 3'h2, 8'h00, 8'h02, 4'd11}, // R11 only edge bit sticks
    '{1'b0, 3'h0, 8'h00, 8'h00, 4'd11}, // R11 unmapped
    '{1'b0, 3'h1, 8'h00, 8'h00, 4'd11}, // R11 unmapped
    '{1'b0, 3'h4, 8'h00, 8'h00, 4'd11}, // R11 unmapped
    '{1'b0, 3'h6, 8'h00, 8'h00, 4'd11}  // R11 unmapped
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWData = '0;
  logic [7:0] busRData;
  logic       strobeIn = 1'b0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_port_latch uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWData(busWData), .busRData(busRData), .strobeIn(strobeIn),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 v = busRData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [2:0] a, input logic [7:0] expv);
    logic [7:0] v;
    readReg(a, v);
    check(req, v, expv);
  endtask

  task automatic strobeTo(input logic lvl, input logic [7:0] pins);
    @(negedge clk);
    pinIn = pins; strobeIn = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    expectReg("R1 status", 3'h2, 8'h00);
    expectReg("R1 latch", 3'h5, 8'h00);
    expectReg("R1 dir", 3'h7, 8'h00);

    pinIn = 8'h3C;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) writeReg(VECS[i].addr, VECS[i].data);
      else begin
        readReg(VECS[i].addr, v);
        checks++;
        if (v !== VECS[i].expv) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual=%02h expected=%02h",
                   VECS[i].req, i, v, VECS[i].expv);
        end
      end
    end
    check("R2 pinOe", pinOe, 8'hF0);
    check("R2 pinOut", pinOut, 8'hA5);
    pinIn = 8'h0F;
    repeat (3) @(negedge clk);
    expectReg("R3 pins follow", 3'h3, 8'hAF);

    // R4 rising capture; R7 latch read first does not clear; R6 clear
    writeReg(3'h2, 8'h02);
    strobeTo(1'b1, 8'h5A);
    expectReg("R7 latch read unarmed", 3'h5, 8'h5A);
    expectReg("R4 flag set rising", 3'h2, 8'h82);
    expectReg("R6 clearing latch read", 3'h5, 8'h5A);
    expectReg("R6 flag cleared", 3'h2, 8'h02);

    // R5 wrong polarity ignored, latch holds
    strobeTo(1'b0, 8'hFF);
    expectReg("R5 no flag on falling", 3'h2, 8'h02);
    expectReg("R5 latch held", 3'h5, 8'h5A);

    // R8 status write disarms
    strobeTo(1'b1, 8'h11);
    expectReg("R8 flag set", 3'h2, 8'h82);
    writeReg(3'h2, 8'h02);
    expectReg("R8 latch", 3'h5, 8'h11);
    expectReg("R8 flag survives", 3'h2, 8'h82);

    // R10 clear-status read does not arm
    expectReg("R10 clear", 3'h5, 8'h11);
    expectReg("R10 flag clear", 3'h2, 8'h02);
    strobeTo(1'b0, 8'h11);
    strobeTo(1'b1, 8'h22);
    expectReg("R10 latch", 3'h5, 8'h22);
    expectReg("R10 flag survives", 3'h2, 8'h82);

    // R9 collision of edge with clearing read
    strobeTo(1'b0, 8'h22);
    expectReg("R9 arm", 3'h2, 8'h82);
    pinIn = 8'h33; strobeIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = 3'h5; busRd = 1'b1;
    #1 v = busRData;
    @(negedge clk);
    busRd = 1'b0;
    check("R9 old latch on read", v, 8'h22);
    expectReg("R9 flag kept", 3'h2, 8'h82);
    expectReg("R9 new latch", 3'h5, 8'h33);

    // R4 falling-edge mode
    writeReg(3'h2, 8'h00);
    strobeTo(1'b0, 8'h44);
    expectReg("R4 flag set falling", 3'h2, 8'h80);
    expectReg("R4 latch falling", 3'h5, 8'h44);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule